// File: doc/BRIEF.md
# Register Block Access Error Responder

This block sits between a bus requester and the register and RAM map of one peripheral. Every request arrives on a generic single-cycle interface that carries a flag saying whether it came from an AHB or an APB master. The block decides whether the addressed word exists and whether the access type is allowed there. Legal accesses go through to a backend port. Illegal ones never reach the backend: a read of an undefined word returns zero, and a write to one is dropped. Each access gets the response its bus expects.

The response differs by bus and direction. APB cannot signal an error, so every APB access completes with ready and OKAY. AHB writes are posted, so they are always acknowledged with OKAY as well. Only an illegal AHB read gets the two-cycle AHB ERROR sequence.

The first illegal access is recorded in a status register. The record holds the byte address, the direction and a cause code. The block also raises a one-cycle event, which is meant to drive an interrupt. Capturing the record locks it. Further violations are neither recorded nor signalled until software pulses the release input.

Top module: `regerr_guard`

## Requirements
- R1: A legal read asserts `bk_rd` in the cycle the request is accepted. In the next cycle `rsp_ready`=1, `rsp_err`=0 and `rsp_rdata` equals `bk_rdata` as it was in the accept cycle. A legal write asserts `bk_wr` in the accept cycle and gets the same single-cycle OKAY response.
- R2: A read of a gap returns `rsp_rdata`=0 and leaves `bk_rd` low.
- R3: A write to a gap or to a read-only word leaves `bk_wr` low, so the data is discarded.
- R4: Every APB access, legal or not, completes in the cycle after acceptance with `rsp_ready`=1 and `rsp_err`=0.
- R5: Every AHB write, including an illegal one, completes in the cycle after acceptance with `rsp_ready`=1 and `rsp_err`=0.
- R6: An illegal AHB read responds over two cycles. The first has `rsp_ready`=0 and `rsp_err`=1. The second has `rsp_ready`=1 and `rsp_err`=1. No request is accepted during the first of these cycles.
- R7: With the default parameters the map is decoded as follows.
  - Register words 0 to 11 (bytes 0x000 to 0x02C) exist.
  - Of these, words 4 to 7 (bytes 0x010 to 0x01C) are read-only. A read of them is legal.
  - Register words 12 to 15 are gaps.
  - RAM occupies bytes 0x100 to 0x1FC.
  - Every other address is a gap.
- R8: While unlocked, an illegal access is captured. In the cycle after acceptance `err_event` is high for exactly one cycle and `st_locked`=1. `st_addr` holds the byte address and `st_write` is 1 for a write. `st_cause` is 2'b01 for a write to a read-only word and 2'b10 for a gap.
- R9: While `st_locked`=1, further illegal accesses change neither `st_addr`, `st_write` nor `st_cause`, and they raise no `err_event`.
- R10: A one-cycle pulse on `err_unlock` clears `st_locked` from the next cycle on. The old record stays visible until the next capture, and the next illegal access is captured again.
- R11: After reset `rsp_ready`, `rsp_err`, `err_event` and `st_locked` are 0, and `st_addr`, `st_write` and `st_cause` are zero.

Address bits [1:0] take no part in decoding and are kept only in the record. At most one request is offered per cycle. `bk_rdata` must be valid in the same cycle that `bk_rd` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_ahb | input | 1 | 1 = AHB request, 0 = APB request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data returned to the requester |
| rsp_ready | output | 1 | Access completes this cycle |
| rsp_err | output | 1 | Error response (AHB read only) |
| bk_rd | output | 1 | Legal read forwarded to the backend |
| bk_wr | output | 1 | Legal write forwarded to the backend |
| bk_addr | output | ADDR_W-2 | Word address to the backend |
| bk_wdata | output | DATA_W | Write data to the backend |
| bk_rdata | input | DATA_W | Backend read data, same cycle as bk_rd |
| err_event | output | 1 | One-cycle pulse on each captured violation |
| err_unlock | input | 1 | Software release of the capture lock |
| st_locked | output | 1 | Record is locked |
| st_addr | output | ADDR_W | Byte address of the recorded violation |
| st_write | output | 1 | Direction of the recorded violation |
| st_cause | output | 2 | 01 = write to read-only word, 10 = gap |

## Verification
A decode fault shows up in the accept cycle itself: `bk_rd` or `bk_wr` appears for an address that should be dropped, or fails to appear for a legal one. A response state machine stuck in or skipping its error phase shows one cycle later, as a wrong `rsp_ready`/`rsp_err` pair or as a missing second error cycle. A lock that is set or cleared wrongly is visible one cycle after the next illegal access: an extra or missing `err_event`, or a record that changed when it should have held.

// File: rtl/regerr_pkg.sv
// Shared types for the access error responder.
// Assumes: it is compiled before every other file of the block.
package regerr_pkg;

    // Decoded class of the addressed word.
    typedef enum logic [1:0] {
        CLS_RW  = 2'd0,
        CLS_RO  = 2'd1,
        CLS_GAP = 2'd2
    } cls_e;

    // Cause code kept in the error record (the encoding is visible on st_cause).
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_ROWR = 2'b01,
        CAUSE_GAP  = 2'b10
    } cause_e;

    // States of the response sequencer.
    typedef enum logic [1:0] {
        RS_IDLE,
        RS_OK,
        RS_ERR1,
        RS_ERR2
    } rsp_st_e;

endpackage

// File: rtl/regerr_decode.sv
// Address classifier: maps a word address onto read/write, read-only or gap.
// Assumes: the register window and the RAM window do not overlap, and the
// base addresses are word aligned. Purely combinational.
module regerr_decode
    import regerr_pkg::*;
#(
    parameter int                   WA_W      = 14,
    parameter logic [31:0]          REG_BASE  = 32'h0000_0000,
    parameter int                   REG_WORDS = 16,
    parameter logic [REG_WORDS-1:0] REG_VALID = 16'h0FFF,
    parameter logic [REG_WORDS-1:0] REG_RO    = 16'h00F0,
    parameter logic [31:0]          RAM_BASE  = 32'h0000_0100,
    parameter int                   RAM_WORDS = 64
) (
    input  logic [WA_W-1:0] wa,
    output cls_e            cls
);

    localparam logic [31:0] REG_WB = REG_BASE >> 2;
    localparam logic [31:0] RAM_WB = RAM_BASE >> 2;
    localparam logic [31:0] RAM_WE = RAM_WB + 32'(RAM_WORDS);

    logic [31:0]          wa32;
    logic [REG_WORDS-1:0] hit;
    logic                 live_hit;
    logic                 ro_hit;
    logic                 in_ram;

    assign wa32 = {{(32-WA_W){1'b0}}, wa};

    // One comparator per register word.
    for (genvar i = 0; i < REG_WORDS; i++) begin : g_word
        assign hit[i] = (wa32 == REG_WB + 32'(i));
    end

    assign live_hit = |(hit & REG_VALID);
    assign ro_hit   = |(hit & REG_VALID & REG_RO);
    assign in_ram   = (wa32 >= RAM_WB) && (wa32 < RAM_WE);

    // Resolve the class: read-only first, then any live word, then gap.
    always_comb begin
        if (ro_hit)                 cls = CLS_RO;
        else if (live_hit || in_ram) cls = CLS_RW;
        else                        cls = CLS_GAP;
    end

endmodule

// File: rtl/regerr_resp.sv
// Response sequencer: one OKAY cycle, or the two-cycle ERROR pair for an
// illegal AHB read. Read data are registered with the response.
// Assumes: acc is never raised while busy is high.
module regerr_resp
    import regerr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              is_ahb,
    input  logic              is_write,
    input  logic              legal,
    input  logic [DATA_W-1:0] bk_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              err,
    output logic              busy
);

    rsp_st_e state;

    // Advance the sequencer and latch the returned read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            rdata <= '0;
        end else begin
            rdata <= '0;
            if (acc) begin
                if (is_ahb && !is_write && !legal) state <= RS_ERR1;
                else                               state <= RS_OK;
                if (legal && !is_write)            rdata <= bk_rdata;
            end else if (state == RS_ERR1) begin
                state <= RS_ERR2;
            end else begin
                state <= RS_IDLE;
            end
        end
    end

    assign ready = (state == RS_OK) || (state == RS_ERR2);
    assign err   = (state == RS_ERR1) || (state == RS_ERR2);
    assign busy  = (state == RS_ERR1);

    // The first error cycle is always followed by the completing one.
    p_err_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !ready) |=> (err && ready));

    // A completing error cycle never appears without its first half.
    p_err_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && ready) |-> $past(err && !ready));

endmodule

// File: rtl/regerr_capture.sv
// Error record with lock: keeps the first violation and pulses an event;
// the lock holds the record until err_unlock is pulsed.
// Assumes: flag is already qualified by request acceptance.
module regerr_capture
    import regerr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  cause_e            cause,
    input  logic              unlock,
    output logic              locked,
    output logic [ADDR_W-1:0] rec_addr,
    output logic              rec_write,
    output cause_e            rec_cause,
    output logic              evt
);

    // Record on the first violation while unlocked, otherwise honour a release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked    <= 1'b0;
            rec_addr  <= '0;
            rec_write <= 1'b0;
            rec_cause <= CAUSE_NONE;
            evt       <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (flag && !locked) begin
                rec_addr  <= addr;
                rec_write <= is_write;
                rec_cause <= cause;
                locked    <= 1'b1;
                evt       <= 1'b1;
            end else if (unlock) begin
                locked <= 1'b0;
            end
        end
    end

    // An event is only ever seen together with a held lock.
    p_event_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> locked);

    // Without a release the locked record does not move.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !unlock) |=> (locked && $stable(rec_addr) && $stable(rec_cause) && !evt));

    // A release with nothing new to capture leaves the record unlocked.
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && unlock) |=> !locked);

endmodule

// File: rtl/regerr_guard.sv
// Top of the access error responder: accepts one request per cycle,
// classifies it, forwards legal accesses to the backend, drives the
// bus-specific response and maintains the locked error record.
// Assumes: bk_rdata is valid combinationally in the cycle bk_rd is high.
module regerr_guard
    import regerr_pkg::*;
#(
    parameter int                   ADDR_W    = 16,
    parameter int                   DATA_W    = 32,
    parameter logic [31:0]          REG_BASE  = 32'h0000_0000,
    parameter int                   REG_WORDS = 16,
    parameter logic [REG_WORDS-1:0] REG_VALID = 16'h0FFF,
    parameter logic [REG_WORDS-1:0] REG_RO    = 16'h00F0,
    parameter logic [31:0]          RAM_BASE  = 32'h0000_0100,
    parameter int                   RAM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_ahb,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_ready,
    output logic              rsp_err,
    output logic              bk_rd,
    output logic              bk_wr,
    output logic [ADDR_W-3:0] bk_addr,
    output logic [DATA_W-1:0] bk_wdata,
    input  logic [DATA_W-1:0] bk_rdata,
    output logic              err_event,
    input  logic              err_unlock,
    output logic              st_locked,
    output logic [ADDR_W-1:0] st_addr,
    output logic              st_write,
    output logic [1:0]        st_cause
);

    localparam int WA_W = ADDR_W - 2;

    cls_e   cls;
    cause_e cause;
    cause_e rec_cause;
    logic   busy;
    logic   acc;
    logic   legal;

    regerr_decode #(
        .WA_W      (WA_W),
        .REG_BASE  (REG_BASE),
        .REG_WORDS (REG_WORDS),
        .REG_VALID (REG_VALID),
        .REG_RO    (REG_RO),
        .RAM_BASE  (RAM_BASE),
        .RAM_WORDS (RAM_WORDS)
    ) u_decode (
        .wa  (req_addr[ADDR_W-1:2]),
        .cls (cls)
    );

    // Accept unless the first error cycle is in progress.
    assign acc = req_valid && !busy;

    // Reads are legal on any existing word, writes only on writable ones.
    always_comb begin
        if (req_write) legal = (cls == CLS_RW);
        else           legal = (cls != CLS_GAP);
    end

    // Pick the cause code for a rejected access.
    always_comb begin
        if (cls == CLS_GAP) cause = CAUSE_GAP;
        else                cause = CAUSE_ROWR;
    end

    assign bk_rd    = acc && !req_write && legal;
    assign bk_wr    = acc &&  req_write && legal;
    assign bk_addr  = req_addr[ADDR_W-1:2];
    assign bk_wdata = req_wdata;

    regerr_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .is_ahb   (req_is_ahb),
        .is_write (req_write),
        .legal    (legal),
        .bk_rdata (bk_rdata),
        .rdata    (rsp_rdata),
        .ready    (rsp_ready),
        .err      (rsp_err),
        .busy     (busy)
    );

    regerr_capture #(
        .ADDR_W (ADDR_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag      (acc && !legal),
        .addr      (req_addr),
        .is_write  (req_write),
        .cause     (cause),
        .unlock    (err_unlock),
        .locked    (st_locked),
        .rec_addr  (st_addr),
        .rec_write (st_write),
        .rec_cause (rec_cause),
        .evt       (err_event)
    );

    assign st_cause = rec_cause;

    // An error phase only ever starts from an AHB read that the backend did not serve.
    p_err_ahb_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err && !rsp_ready) |-> $past(req_valid && req_is_ahb && !req_write && !bk_rd));

    // A served read completes with OKAY in the following cycle.
    p_read_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bk_rd |=> (rsp_ready && !rsp_err));

    // Nothing is forwarded to the backend while the first error cycle holds the bus.
    p_no_fwd_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err && !rsp_ready) |-> !(bk_rd || bk_wr));

endmodule

// File: tb/regerr_guard_tb_top.sv
// Directed bench for regerr_guard: one task per scenario, each checking itself.
module regerr_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_is_ahb = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_ready;
    logic              rsp_err;
    logic              bk_rd;
    logic              bk_wr;
    logic [ADDR_W-3:0] bk_addr;
    logic [DATA_W-1:0] bk_wdata;
    logic [DATA_W-1:0] bk_rdata;
    logic              err_event;
    logic              err_unlock = 1'b0;
    logic              st_locked;
    logic [ADDR_W-1:0] st_addr;
    logic              st_write;
    logic [1:0]        st_cause;

    int n_checks = 0;
    int n_fails  = 0;

    // Backend model: data tagged with the word address.
    assign bk_rdata = 32'hC0DE_0000 | {18'b0, bk_addr};

    always #(CLK_PERIOD/2) clk = ~clk;

    regerr_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_is_ahb(req_is_ahb), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
        .bk_rd(bk_rd), .bk_wr(bk_wr), .bk_addr(bk_addr), .bk_wdata(bk_wdata),
        .bk_rdata(bk_rdata), .err_event(err_event), .err_unlock(err_unlock),
        .st_locked(st_locked), .st_addr(st_addr), .st_write(st_write), .st_cause(st_cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Observations of one access.
    logic        o_rd, o_wr, o_rdy1, o_err1, o_evt1, o_rdy2, o_err2;
    logic [31:0] o_data;

    // Offer one request at a negedge; sample the accept cycle, then two response cycles.
    task automatic access(input logic ahb, input logic wr, input logic [15:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_is_ahb = ahb; req_write = wr;
        req_addr = a; req_wdata = 32'h1234_5678;
        #1;
        o_rd = bk_rd; o_wr = bk_wr;
        @(negedge clk);
        req_valid = 1'b0;
        o_rdy1 = rsp_ready; o_err1 = rsp_err; o_evt1 = err_event; o_data = rsp_rdata;
        @(negedge clk);
        o_rdy2 = rsp_ready; o_err2 = rsp_err;
    endtask

    task automatic pulse_unlock();
        @(negedge clk);
        err_unlock = 1'b1;
        @(negedge clk);
        err_unlock = 1'b0;
        check("R10 lock cleared", {31'b0, st_locked}, 32'd0);
    endtask

    task automatic t_reset();
        check("R11 ready", {31'b0, rsp_ready}, 0);
        check("R11 err", {31'b0, rsp_err}, 0);
        check("R11 event", {31'b0, err_event}, 0);
        check("R11 locked", {31'b0, st_locked}, 0);
        check("R11 record", {14'b0, st_write, st_cause, st_addr}, 0);
    endtask

    task automatic t_legal();
        access(1'b0, 1'b0, 16'h0008);
        check("R1 bk_rd", {31'b0, o_rd}, 1);
        check("R1 ready/err", {30'b0, o_rdy1, o_err1}, 32'b10);
        check("R1 rdata", o_data, 32'hC0DE_0002);
        check("R1 single cycle", {31'b0, o_rdy2}, 0);
        access(1'b1, 1'b0, 16'h01FC);
        check("R7 RAM top read", o_data, 32'hC0DE_007F);
        check("R1 AHB read ok", {30'b0, o_rdy1, o_err1}, 32'b10);
        access(1'b1, 1'b1, 16'h0004);
        check("R1 bk_wr", {31'b0, o_wr}, 1);
        check("R5 AHB write ok", {30'b0, o_rdy1, o_err1}, 32'b10);
        access(1'b0, 1'b0, 16'h0010);
        check("R7 read-only read legal", o_data, 32'hC0DE_0004);
        check("R7 no event", {31'b0, o_evt1}, 0);
    endtask

    task automatic t_apb_gap_read();
        access(1'b0, 1'b0, 16'h0030);
        check("R2 no bk_rd", {31'b0, o_rd}, 0);
        check("R2 zero data", o_data, 0);
        check("R4 APB ok", {30'b0, o_rdy1, o_err1}, 32'b10);
        check("R8 event", {31'b0, o_evt1}, 1);
        check("R8 locked", {31'b0, st_locked}, 1);
        check("R8 record", {14'b0, st_write, st_cause, st_addr}, {14'b0, 1'b0, 2'b10, 16'h0030});
    endtask

    task automatic t_locked();
        access(1'b1, 1'b1, 16'h0014);
        check("R3 RO write dropped", {31'b0, o_wr}, 0);
        check("R5 illegal AHB write ok", {30'b0, o_rdy1, o_err1}, 32'b10);
        check("R9 no event", {31'b0, o_evt1}, 0);
        check("R9 record held", {14'b0, st_write, st_cause, st_addr}, {14'b0, 1'b0, 2'b10, 16'h0030});
        pulse_unlock();
        check("R10 record kept", {16'b0, st_addr}, 32'h0030);
    endtask

    task automatic t_ahb_err_read();
        access(1'b1, 1'b0, 16'h0200);
        check("R6 first cycle", {30'b0, o_rdy1, o_err1}, 32'b01);
        check("R6 second cycle", {30'b0, o_rdy2, o_err2}, 32'b11);
        check("R2 no bk_rd", {31'b0, o_rd}, 0);
        check("R2 zero data", o_data, 0);
        check("R10 recapture event", {31'b0, o_evt1}, 1);
        check("R8 record", {14'b0, st_write, st_cause, st_addr}, {14'b0, 1'b0, 2'b10, 16'h0200});
        pulse_unlock();
    endtask

    task automatic t_ro_write();
        access(1'b0, 1'b1, 16'h001C);
        check("R3 no bk_wr", {31'b0, o_wr}, 0);
        check("R4 APB write ok", {30'b0, o_rdy1, o_err1}, 32'b10);
        check("R8 RO cause", {14'b0, st_write, st_cause, st_addr}, {14'b0, 1'b1, 2'b01, 16'h001C});
        pulse_unlock();
        access(1'b1, 1'b1, 16'h0080);
        check("R3 gap write dropped", {31'b0, o_wr}, 0);
        check("R5 gap write ok", {30'b0, o_rdy1, o_err1}, 32'b10);
        check("R8 gap write cause", {14'b0, st_write, st_cause, st_addr}, {14'b0, 1'b1, 2'b10, 16'h0080});
        pulse_unlock();
        access(1'b0, 1'b0, 16'h00FC);
        check("R7 below RAM is gap", {31'b0, o_evt1}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legal();
        t_apb_gap_read();
        t_locked();
        t_ahb_err_read();
        t_ro_write();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule